// File: doc/BRIEF.md
# Range Request Chunking Sequencer

This block sits in front of a cache range engine. It takes one byte-range maintenance request (invalidate, clean or flush) whose end address is exclusive. It breaks the request into a stream of commands that the engine can take. There are two kinds of command:

- single-line clean-and-invalidate commands for partial edge lines;
- inclusive range commands covering whole lines.

No range command is longer than a maximum span, and none crosses a page boundary.

A write-through mode input is sampled with each request. When it is set, the cache holds no dirty data. Clean work is then skipped, and a flush turns into an invalidate. After the last command of a request has been accepted, the block pulses `done` for one cycle. It also pulses `done` for a request that produced no commands. Only then does it take another request.

Top module: `rcs_seq`

## Requirements
- R1: Range commands are inclusive. A chunk covering lines from `cur` up to an exclusive bound `hi` is issued with start `cur` and end `hi - 32`. A single-line command carries the same line address in start and end. Command kind codes are: 0 = single-line clean-and-invalidate, 1 = range clean, 2 = range invalidate.
- R2: Each chunk's exclusive bound is the smallest of three values: the (rounded) request end, `cur + 1024`, and the first 4096-byte page boundary above `cur`. Chunks are issued in ascending address order until `cur` reaches or passes the end.
- R3: For an invalidate (op code 0) whose start is not 32-byte aligned, the first command is a single-line clean-and-invalidate of the line holding the start. Range work then begins at the next line.
- R4: For an invalidate whose end is not 32-byte aligned, a single-line clean-and-invalidate of the line holding the end follows any R3 command. Range work then stops at that line's base address.
- R5: For clean (op code 1) and flush (op code 2), the start is rounded down and the end is rounded up to 32-byte boundaries before chunking.
- R6: With the write-through mode set, a clean emits no commands and a flush emits only range invalidate commands.
- R7: With the write-through mode clear, a flush emits, for each chunk, a range clean followed by a range invalidate of the same bounds, before it moves to the next chunk.
- R8: `done` is high for exactly one cycle: the cycle after the last command handshake, or for a request with no commands, the cycle after the request was accepted. `done` is never high while a command is offered.
- R9: `req_ready` is high only when no request is being sequenced. Requests presented while busy are ignored.
- R10: An offered command holds its kind, start and end unchanged until it is accepted.
- R11: Op code 3 is a no-operation: it emits no commands and still yields a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no-op |
| req_start | input | AW | First byte address of the range |
| req_end | input | AW | Exclusive end byte address |
| wt_override | input | 1 | Write-through mode, sampled with the request |
| cmd_valid | output | 1 | Command offered to the range engine |
| cmd_ready | input | 1 | Range engine takes the command |
| cmd_kind | output | 2 | Command kind (see R1) |
| cmd_start | output | AW | Inclusive first line address |
| cmd_end | output | AW | Inclusive last line address |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
Directed requests cover specific edge cases:
- invalidates with both edges partial, including both edges inside one line, which separate the order of the R3 and R4 commands and their effect on the range bounds;
- aligned cleans longer than the span, which show the span cap;
- flushes that cross a page, which show page clipping and the clean/invalidate pairing;
- write-through cleans, no-op requests and empty ranges, which check the zero-command `done` pulse.

Random requests of random length, operation and mode are run under random back-pressure and compared command by command against a bench model. Some of them also hold a second request on the port while busy, so an accepted intruder would show up as extra or wrong commands.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    OP_INVAL = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NONE  = 2'd3
  } rcs_op_e;

  typedef enum logic [1:0] {
    K_LINE_CI     = 2'd0,
    K_RANGE_CLEAN = 2'd1,
    K_RANGE_INVAL = 2'd2,
    K_UNUSED      = 2'd3
  } rcs_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HEAD  = 3'd1,
    S_TAIL  = 3'd2,
    S_RUN_A = 3'd3,
    S_RUN_B = 3'd4,
    S_DONE  = 3'd5
  } rcs_state_e;
endpackage

// File: rtl/rcs_edge_plan.sv
module rcs_edge_plan
  import rcs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LINE_LG = 5
) (
  input  rcs_op_e         op,
  input  logic            wt,
  input  logic [AW-1:0]   s_addr,
  input  logic [AW-1:0]   e_addr,
  output logic            head_need,
  output logic [AW-1:0]   head_line,
  output logic            tail_need,
  output logic [AW-1:0]   tail_line,
  output logic [AW:0]     lo,
  output logic [AW:0]     hi,
  output logic            run
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LINE_CW = CW'(1) << LINE_LG;
  localparam logic [CW-1:0] LMASK   = LINE_CW - CW'(1);

  function automatic logic [CW-1:0] line_down(input logic [CW-1:0] a);
    return a & ~LMASK;
  endfunction

  function automatic logic [CW-1:0] line_up(input logic [CW-1:0] a);
    return (a + LMASK) & ~LMASK;
  endfunction

  function automatic logic off_line(input logic [CW-1:0] a);
    return (a & LMASK) != '0;
  endfunction

  logic [CW-1:0] s_x, e_x, s_dn, s_up, e_dn, e_up;
  logic          range_ok;

  assign s_x  = {1'b0, s_addr};
  assign e_x  = {1'b0, e_addr};
  assign s_dn = line_down(s_x);
  assign s_up = line_up(s_x);
  assign e_dn = line_down(e_x);
  assign e_up = line_up(e_x);

  assign head_line = s_dn[AW-1:0];
  assign tail_line = e_dn[AW-1:0];

  always_comb begin
    head_need = 1'b0;
    tail_need = 1'b0;
    lo        = s_dn;
    hi        = e_up;
    range_ok  = 1'b0;
    case (op)
      OP_INVAL: begin
        head_need = off_line(s_x);
        tail_need = off_line(e_x);
        lo        = s_up;
        hi        = e_dn;
        range_ok  = 1'b1;
      end
      OP_CLEAN: range_ok = !wt;
      OP_FLUSH: range_ok = 1'b1;
      default:  range_ok = 1'b0;
    endcase
  end

  assign run = range_ok && (lo < hi);
endmodule

// File: rtl/rcs_chunk_calc.sv
module rcs_chunk_calc #(
  parameter int AW      = 32,
  parameter int LINE_LG = 5,
  parameter int SPAN_LG = 10,
  parameter int PAGE_LG = 12
) (
  input  logic [AW:0]   cur,
  input  logic [AW:0]   stop,
  output logic [AW:0]   chunk_hi,
  output logic          last,
  output logic [AW-1:0] r_start,
  output logic [AW-1:0] r_end
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LINE_CW = CW'(1) << LINE_LG;
  localparam logic [CW-1:0] SPAN_CW = CW'(1) << SPAN_LG;
  localparam logic [CW-1:0] PMASK   = (CW'(1) << PAGE_LG) - CW'(1);

  function automatic logic [CW-1:0] min2(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [CW-1:0] page_next(input logic [CW-1:0] a);
    return (a | PMASK) + CW'(1);
  endfunction

  function automatic logic [CW-1:0] span_next(input logic [CW-1:0] a);
    return a + SPAN_CW;
  endfunction

  logic [CW-1:0] page_bound, end_incl;

  assign page_bound = min2(stop, page_next(cur));

  generate
    if (SPAN_LG < PAGE_LG) begin : g_span_cap
      assign chunk_hi = min2(page_bound, span_next(cur));
    end else begin : g_page_only
      assign chunk_hi = page_bound;
    end
  endgenerate

  assign last     = (chunk_hi >= stop);
  assign end_incl = chunk_hi - LINE_CW;
  assign r_start  = cur[AW-1:0];
  assign r_end    = end_incl[AW-1:0];
endmodule

// File: rtl/rcs_cmd_sel.sv
module rcs_cmd_sel
  import rcs_pkg::*;
#(
  parameter int AW = 32
) (
  input  rcs_state_e    st,
  input  rcs_op_e       op,
  input  logic          wt,
  input  logic [AW-1:0] head_line,
  input  logic [AW-1:0] tail_line,
  input  logic [AW-1:0] r_start,
  input  logic [AW-1:0] r_end,
  output logic          valid,
  output rcs_kind_e     kind,
  output logic [AW-1:0] c_start,
  output logic [AW-1:0] c_end,
  output logic          pair_mode
);
  assign pair_mode = (op == OP_FLUSH) && !wt;

  always_comb begin
    valid   = 1'b0;
    kind    = K_LINE_CI;
    c_start = r_start;
    c_end   = r_end;
    case (st)
      S_HEAD: begin
        valid   = 1'b1;
        c_start = head_line;
        c_end   = head_line;
      end
      S_TAIL: begin
        valid   = 1'b1;
        c_start = tail_line;
        c_end   = tail_line;
      end
      S_RUN_A: begin
        valid = 1'b1;
        if (op == OP_CLEAN || pair_mode) kind = K_RANGE_CLEAN;
        else                             kind = K_RANGE_INVAL;
      end
      S_RUN_B: begin
        valid = 1'b1;
        kind  = K_RANGE_INVAL;
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
  import rcs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LINE_LG = 5,
  parameter int SPAN_LG = 10,
  parameter int PAGE_LG = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  input  logic          wt_override,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_start,
  output logic [AW-1:0] cmd_end,
  output logic          done
);
  localparam int CW = AW + 1;

  rcs_state_e    state;
  rcs_op_e       op_q;
  logic          wt_q, tail_q, run_q;
  logic [AW-1:0] head_q, tail_line_q;
  logic [CW-1:0] cur_q, stop_q;

  // plan of a request presented at the port
  logic          p_head, p_tail, p_run;
  logic [AW-1:0] p_head_line, p_tail_line;
  logic [CW-1:0] p_lo, p_hi;

  // chunk arithmetic on the live range
  logic [CW-1:0] chunk_hi;
  logic          chunk_last;
  logic [AW-1:0] r_start, r_end;

  rcs_kind_e     kind_w;
  logic          pair_mode;

  // named events for the checker
  logic evt_req_acc, evt_cmd_acc, evt_chunk_adv, busy;

  rcs_edge_plan #(.AW(AW), .LINE_LG(LINE_LG)) u_plan (
    .op        (rcs_op_e'(req_op)),
    .wt        (wt_override),
    .s_addr    (req_start),
    .e_addr    (req_end),
    .head_need (p_head),
    .head_line (p_head_line),
    .tail_need (p_tail),
    .tail_line (p_tail_line),
    .lo        (p_lo),
    .hi        (p_hi),
    .run       (p_run)
  );

  rcs_chunk_calc #(.AW(AW), .LINE_LG(LINE_LG), .SPAN_LG(SPAN_LG), .PAGE_LG(PAGE_LG)) u_chunk (
    .cur      (cur_q),
    .stop     (stop_q),
    .chunk_hi (chunk_hi),
    .last     (chunk_last),
    .r_start  (r_start),
    .r_end    (r_end)
  );

  rcs_cmd_sel #(.AW(AW)) u_sel (
    .st        (state),
    .op        (op_q),
    .wt        (wt_q),
    .head_line (head_q),
    .tail_line (tail_line_q),
    .r_start   (r_start),
    .r_end     (r_end),
    .valid     (cmd_valid),
    .kind      (kind_w),
    .c_start   (cmd_start),
    .c_end     (cmd_end),
    .pair_mode (pair_mode)
  );

  assign cmd_kind      = kind_w;
  assign req_ready     = (state == S_IDLE);
  assign done          = (state == S_DONE);
  assign busy          = (state != S_IDLE);
  assign evt_req_acc   = req_valid && req_ready;
  assign evt_cmd_acc   = cmd_valid && cmd_ready;
  assign evt_chunk_adv = evt_cmd_acc &&
                         ((state == S_RUN_B) || (state == S_RUN_A && !pair_mode));

  function automatic rcs_state_e after_edges(input logic tail_left, input logic run_left);
    if (tail_left) return S_TAIL;
    if (run_left)  return S_RUN_A;
    return S_DONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= OP_NONE;
      wt_q        <= 1'b0;
      tail_q      <= 1'b0;
      run_q       <= 1'b0;
      head_q      <= '0;
      tail_line_q <= '0;
      cur_q       <= '0;
      stop_q      <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q        <= rcs_op_e'(req_op);
            wt_q        <= wt_override;
            tail_q      <= p_tail;
            run_q       <= p_run;
            head_q      <= p_head_line;
            tail_line_q <= p_tail_line;
            cur_q       <= p_lo;
            stop_q      <= p_hi;
            state       <= p_head ? S_HEAD : after_edges(p_tail, p_run);
          end
        end
        S_HEAD:  if (cmd_ready) state <= after_edges(tail_q, run_q);
        S_TAIL:  if (cmd_ready) state <= after_edges(1'b0, run_q);
        S_RUN_A: begin
          if (cmd_ready) begin
            if (pair_mode) begin
              state <= S_RUN_B;
            end else begin
              cur_q <= chunk_hi;
              state <= chunk_last ? S_DONE : S_RUN_A;
            end
          end
        end
        S_RUN_B: begin
          if (cmd_ready) begin
            cur_q <= chunk_hi;
            state <= chunk_last ? S_DONE : S_RUN_A;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcs_seq_chk.sv
module rcs_seq_chk #(
  parameter int AW      = 32,
  parameter int LINE_LG = 5,
  parameter int SPAN_LG = 10,
  parameter int PAGE_LG = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_kind,
  input logic [AW-1:0] cmd_start,
  input logic [AW-1:0] cmd_end,
  input logic          done,
  input logic          busy,
  input logic          evt_cmd_acc,
  input logic          pair_mode,
  input logic          wt_q
);
  localparam logic [AW-1:0] LMASK    = (AW'(1) << LINE_LG) - AW'(1);
  localparam logic [AW-1:0] SPAN_MAX = (AW'(1) << SPAN_LG) - (AW'(1) << LINE_LG);

  logic is_range;
  assign is_range = cmd_valid && (cmd_kind != 2'd0);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_start) && $stable(cmd_end)); // R10
  AST_RANGE_INCL: assert property (@(posedge clk) disable iff (!rst_n)
    is_range |-> cmd_start <= cmd_end); // R1
  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |-> cmd_start == cmd_end); // R1
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_start & LMASK) == '0) && ((cmd_end & LMASK) == '0)); // R5
  AST_SPAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_range |-> (cmd_end - cmd_start) <= SPAN_MAX); // R2
  AST_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    is_range |-> (cmd_start >> PAGE_LG) == (cmd_end >> PAGE_LG)); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid); // R8
  AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_acc && pair_mode && cmd_kind == 2'd1 |=>
      cmd_valid && cmd_kind == 2'd2 && $stable(cmd_start) && $stable(cmd_end)); // R7
  AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt_q |-> cmd_kind != 2'd1); // R6
endmodule

bind rcs_seq rcs_seq_chk #(.AW(AW), .LINE_LG(LINE_LG), .SPAN_LG(SPAN_LG), .PAGE_LG(PAGE_LG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_kind    (cmd_kind),
  .cmd_start   (cmd_start),
  .cmd_end     (cmd_end),
  .done        (done),
  .busy        (busy),
  .evt_cmd_acc (evt_cmd_acc),
  .pair_mode   (pair_mode),
  .wt_q        (wt_q)
);

// File: tb/tb_rcs_seq.sv
module tb_rcs_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic          wt_override = 1'b0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_start;
  logic [AW-1:0] cmd_end;
  logic          done;

  int checks = 0;
  int errors = 0;

  int     q_kind[$];
  longint q_s[$];
  longint q_e[$];
  string  q_tag[$];

  always #5 clk = ~clk;

  rcs_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end),
    .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_start(cmd_start), .cmd_end(cmd_end), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input longint s, input longint e, input string tag);
    q_kind.push_back(k);
    q_s.push_back(s);
    q_e.push_back(e);
    q_tag.push_back(tag);
  endtask

  // bench model of the command stream, byte arithmetic with remainders
  task automatic build(input int op, input longint s, input longint e, input bit wt);
    longint st = s;
    longint en = e;
    q_kind.delete(); q_s.delete(); q_e.delete(); q_tag.delete();
    if (op == 3) return;
    if (op == 0) begin
      if (st % 32 != 0) begin
        push(0, st - st % 32, st - st % 32, "R3");
        st = st - st % 32 + 32;
      end
      if (en % 32 != 0) begin
        push(0, en - en % 32, en - en % 32, "R4");
        en = en - en % 32;
      end
    end else begin
      st = st - st % 32;
      if (en % 32 != 0) en = en + 32 - en % 32;
      if (op == 1 && wt) return;
    end
    while (st < en) begin
      longint ce = en;
      longint pg = (st / 4096 + 1) * 4096;
      if (st + 1024 < ce) ce = st + 1024;
      if (pg < ce) ce = pg;
      if (op == 2 && !wt) begin
        push(1, st, ce - 32, "R7");
        push(2, st, ce - 32, "R7");
      end else if (op == 1) push(1, st, ce - 32, "R5");
      else if (op == 2)     push(2, st, ce - 32, "R6");
      else                  push(2, st, ce - 32, "R2");
      st = ce;
    end
  endtask

  task automatic run_req(input int op, input longint s, input longint e, input bit wt,
                         input bit junk, input string tag);
    int idx = 0;
    bit hs_prev = 0;
    bit got_done = 0;
    bit held = 0;
    int h_kind = 0;
    longint h_s = 0, h_e = 0;
    build(op, s, e, wt);
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
    req_valid = 1'b1; req_op = 2'(op); req_start = AW'(s); req_end = AW'(e); wt_override = wt;
    @(negedge clk);
    if (junk) begin
      req_op = 2'($urandom); req_start = $urandom; req_end = $urandom; wt_override = 1'($urandom);
    end else req_valid = 1'b0;
    for (int c = 0; c < 20000 && !got_done; c++) begin
      if (c > 0) @(negedge clk);
      if (held) begin
        check(cmd_valid && int'(cmd_kind) == h_kind && longint'(cmd_start) == h_s &&
              longint'(cmd_end) == h_e, "R10 hold", longint'(cmd_start), h_s);
      end
      held = 0;
      if (done) begin
        check(idx == q_kind.size(), {tag, " count"}, idx, q_kind.size());
        if (q_kind.size() > 0) check(hs_prev, "R8 done timing", hs_prev, 1);
        check(!cmd_valid, "R8 quiet", cmd_valid, 0);
        got_done = 1;
        req_valid = 1'b0;
      end else begin
        bit rdy = ($urandom % 4) != 0;
        if (req_valid) check(!req_ready, "R9 busy", req_ready, 0);
        cmd_ready = rdy;
        hs_prev = 0;
        if (cmd_valid && rdy) begin
          if (idx >= q_kind.size()) begin
            check(0, "R1 extra command", longint'(cmd_start), -1);
          end else begin
            check(int'(cmd_kind) == q_kind[idx], {q_tag[idx], "/R1 kind"}, cmd_kind, q_kind[idx]);
            check(longint'(cmd_start) == q_s[idx], {q_tag[idx], "/R1 start"}, cmd_start, q_s[idx]);
            check(longint'(cmd_end) == q_e[idx], {q_tag[idx], "/R1 end"}, cmd_end, q_e[idx]);
          end
          idx++;
          hs_prev = 1;
        end else if (cmd_valid) begin
          held = 1; h_kind = int'(cmd_kind); h_s = longint'(cmd_start); h_e = longint'(cmd_end);
        end
      end
    end
    if (!got_done) check(0, "R8 no done", 0, 1);
    cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    check(cmd_valid == 1'b0, "R8 reset valid", cmd_valid, 0);
    check(done == 1'b0, "R8 reset done", done, 0);
    rst_n = 1'b1;
    void'($urandom(32'h5eed_1234));
    // directed corner cases
    run_req(0, 64'h1010, 64'h1ff8, 0, 0, "R3");
    run_req(0, 64'h10,   64'h18,   0, 1, "R4");
    run_req(1, 64'h0,    64'h2000, 1, 0, "R6");
    run_req(2, 64'h100,  64'h900,  1, 1, "R6");
    run_req(2, 64'hf00,  64'h1500, 0, 0, "R7");
    run_req(1, 64'h0,    64'h1000, 0, 0, "R2");
    run_req(3, 64'h40,   64'h4000, 0, 0, "R11");
    run_req(0, 64'h40,   64'h40,   0, 0, "R8");
    run_req(1, 64'h123,  64'h3f1,  0, 0, "R5");
    run_req(0, 64'h7fe0, 64'h8421, 0, 1, "R2");
    // constrained random
    for (int i = 0; i < 300; i++) begin
      longint s = longint'($urandom % 32'h40000);
      longint e = s + longint'($urandom % 5000);
      run_req(int'($urandom % 4), s, e, 1'($urandom), 1'($urandom), "R2");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R8: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule